// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block watches the read accesses presented to a 13-bit-addressed static memory and recognises a fixed six-step pattern of addresses that software uses to ask for a nonvolatile save (store) or restore (recall). An access is counted once per chip-enable low pulse. The first five addresses form a fixed prefix and the sixth address chooses the operation. When the pattern completes, the block raises a one-cycle `store_req` or `recall_req` pulse for the transfer engine. It then locks out all further accesses until that engine has shown, through `busy`, that the operation has started and then finished.

All inputs are synchronous to `clk`. The block samples the address, `we_n` and `busy` on the first clock edge at which `ce_n` is seen low after having been high. The output-enable level plays no part. Any write, any access made while `busy` is set, or any address other than the expected one breaks the pattern. A read of address 0x0000 after a break counts at once as the first step again.

The controller has eight named states. `ST_IDLE` means no step is matched. `ST_MATCH1` to `ST_MATCH5` mean one to five steps are matched. `ST_LOCK_ARM` waits for `busy` to rise, and `ST_LOCK_RUN` waits for it to fall. Its transitions are:
- advance (`ST_IDLE`…`ST_MATCH4` to the next state on the expected read);
- restart (to `ST_MATCH1` on a read of 0x0000 that does not advance);
- abort (to `ST_IDLE` on a write, a busy access or a wrong address);
- fire (`ST_MATCH5` to `ST_LOCK_ARM` on a read of 0x0F0F or 0x0F0E);
- engage (`ST_LOCK_ARM` to `ST_LOCK_RUN` when `busy` is high);
- release (`ST_LOCK_RUN` to `ST_IDLE` when `busy` is low).

Top module: `unlock_seq_detect`

## Requirements
- R1: After reset, `progress` is 0 and `store_req` and `recall_req` are low.
- R2: An access is taken only on the first clock edge at which `ce_n` is low after being high. Holding `ce_n` low for further cycles, or changing the address while it stays low, adds no step.
- R3: Read accesses to 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, step `progress` through 1, 2, 3, 4 and 5. Each value appears in the cycle after the clock edge that takes the access.
- R4: With `progress` at 5, a read of 0x0F0F raises `store_req` for exactly one cycle, in the cycle after the taking edge. No earlier write is needed.
- R5: With `progress` at 5, a read of 0x0F0E raises `recall_req` for exactly one cycle, in the cycle after the taking edge.
- R6: An access with `we_n` low returns `progress` to 0 from any step 0 to 5, whatever its address, even 0x0000.
- R7: A read of an unexpected address returns `progress` to 0. If that address is 0x0000, `progress` becomes 1 instead.
- R8: The level of `oe_n` has no effect on any output.
- R9: An access taken while `busy` is high, with `progress` from 0 to 5, returns `progress` to 0 and issues no request.
- R10: After a request, `progress` reads 6 and every access is ignored. This lasts until `busy` has been seen high and then low. `progress` returns to 0 in the cycle after the edge that sees `busy` low.
- R11: `store_req` and `recall_req` are never high together. Each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 13 | Memory address of the current access |
| ce_n | input | 1 | Chip enable, active low; each low pulse is one access |
| we_n | input | 1 | Write enable, active low; low marks the access as a write |
| oe_n | input | 1 | Output enable, active low; has no effect |
| busy | input | 1 | High while a nonvolatile transfer is running |
| store_req | output | 1 | One-cycle request for a store |
| recall_req | output | 1 | One-cycle request for a recall |
| progress | output | 3 | 0 to 5 = steps matched; 6 = locked until the transfer ends |

## Verification
The assertions assume that `ce_n`, `we_n` and `busy` are synchronous, so an access edge is exactly a clock where `ce_n` was high on the previous edge and is low now. They also assume `busy` rises only after a request, because the lock states relate `progress` to the previous cycle's `busy`. The bench drives every input on the falling clock edge. It gives each access one low cycle followed by one high cycle, except in the R2 case, which deliberately holds `ce_n` low. It raises `busy` outside the lock only as part of a single access.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

    localparam int ADDR_W     = 13;
    localparam int PREFIX_LEN = 5;
    localparam int PROG_W     = 3;
    localparam int PAD_W      = 1 << PROG_W;

    localparam logic [PROG_W-1:0] PROG_LOCKED = PROG_W'(PREFIX_LEN + 1);

    // Final-step codes: bit 0 of the sixth address picks the operation.
    localparam logic [ADDR_W-1:0] ADDR_STORE  = 13'h0F0F;
    localparam logic [ADDR_W-1:0] ADDR_RECALL = 13'h0F0E;

    // Encoding of IDLE..MATCH5 equals the number of matched steps.
    typedef enum logic [PROG_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_MATCH1   = 3'd1,
        ST_MATCH2   = 3'd2,
        ST_MATCH3   = 3'd3,
        ST_MATCH4   = 3'd4,
        ST_MATCH5   = 3'd5,
        ST_LOCK_ARM = 3'd6,
        ST_LOCK_RUN = 3'd7
    } ulk_state_e;

    // Expected address for prefix position idx (0 is the first access).
    function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
        logic [ADDR_W-1:0] a;
        case (idx)
            0:       a = 13'h0000;
            1:       a = 13'h1555;
            2:       a = 13'h0AAA;
            3:       a = 13'h1FFF;
            4:       a = 13'h10F0;
            default: a = '0;
        endcase
        return a;
    endfunction

    function automatic logic [PROG_W-1:0] prog_of(input ulk_state_e s);
        return (s == ST_LOCK_RUN) ? PROG_LOCKED : PROG_W'(s);
    endfunction

endpackage

// File: rtl/ulk_access_edge.sv
module ulk_access_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic acc
);
    // Previous enable level; resets high so a low level held through reset
    // still counts as one fresh access.
    logic ce_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev_q <= 1'b1;
        end else begin
            ce_prev_q <= ce_n;
        end
    end

    assign acc = ce_prev_q & ~ce_n;

endmodule

// File: rtl/ulk_step_match.sv
module ulk_step_match
    import ulk_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output logic                  hit_first,
    output logic                  hit_store,
    output logic                  hit_recall
);
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_prefix
        assign prefix_hit[g] = (addr == prefix_addr(g));
    end

    assign hit_first  = prefix_hit[0];
    assign hit_store  = (addr == ADDR_STORE);
    assign hit_recall = (addr == ADDR_RECALL);

endmodule

// File: rtl/ulk_ctrl.sv
module ulk_ctrl
    import ulk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc,
    input  logic                  we_n,
    input  logic                  busy,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  logic                  hit_first,
    input  logic                  hit_store,
    input  logic                  hit_recall,
    output logic                  store_req,
    output logic                  recall_req,
    output logic [PROG_W-1:0]     progress
);
    ulk_state_e        state_q, state_d;
    logic              fire_store_d, fire_recall_d;
    logic [PROG_W-1:0] step_cur;
    logic [PAD_W-1:0]  hit_pad;
    logic              bad_acc;

    assign step_cur = state_q;
    assign hit_pad  = {{(PAD_W-PREFIX_LEN){1'b0}}, prefix_hit};
    assign bad_acc  = busy | ~we_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d       = state_q;
        fire_store_d  = 1'b0;
        fire_recall_d = 1'b0;
        unique case (state_q)
            ST_LOCK_ARM: begin
                if (busy) state_d = ST_LOCK_RUN;        // engage
            end
            ST_LOCK_RUN: begin
                if (!busy) state_d = ST_IDLE;           // release
            end
            ST_MATCH5: begin
                if (acc) begin
                    if (bad_acc) begin
                        state_d = ST_IDLE;              // abort
                    end else if (hit_store) begin
                        state_d      = ST_LOCK_ARM;     // fire
                        fire_store_d = 1'b1;
                    end else if (hit_recall) begin
                        state_d       = ST_LOCK_ARM;    // fire
                        fire_recall_d = 1'b1;
                    end else if (hit_first) begin
                        state_d = ST_MATCH1;            // restart
                    end else begin
                        state_d = ST_IDLE;              // abort
                    end
                end
            end
            ST_IDLE, ST_MATCH1, ST_MATCH2, ST_MATCH3, ST_MATCH4: begin
                if (acc) begin
                    if (bad_acc) begin
                        state_d = ST_IDLE;              // abort
                    end else if (hit_pad[step_cur]) begin
                        state_d = ulk_state_e'(step_cur + 3'd1); // advance
                    end else if (hit_first) begin
                        state_d = ST_MATCH1;            // restart
                    end else begin
                        state_d = ST_IDLE;              // abort
                    end
                end
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
            progress   <= '0;
        end else begin
            store_req  <= fire_store_d;
            recall_req <= fire_recall_d;
            progress   <= prog_of(state_d);
        end
    end

endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
    import ulk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy,
    output logic              store_req,
    output logic              recall_req,
    output logic [PROG_W-1:0] progress
);
    logic                  acc;
    logic [PREFIX_LEN-1:0] prefix_hit;
    logic                  hit_first, hit_store, hit_recall;
    logic                  oe_unused;

    // Output enable does not take part in detection.
    assign oe_unused = oe_n;

    ulk_access_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .acc   (acc)
    );

    ulk_step_match match_i (
        .addr       (addr),
        .prefix_hit (prefix_hit),
        .hit_first  (hit_first),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    ulk_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .we_n       (we_n),
        .busy       (busy),
        .prefix_hit (prefix_hit),
        .hit_first  (hit_first),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .store_req  (store_req),
        .recall_req (recall_req),
        .progress   (progress)
    );

endmodule

// File: rtl/ulk_checker.sv
module ulk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       busy,
    input logic       store_req,
    input logic       recall_req,
    input logic [2:0] progress
);
    assert_no_dual_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    assert_store_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    assert_recall_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    assert_store_after_five_R4: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> (progress == 3'd6 && $past(progress) == 3'd5));

    assert_recall_after_five_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> (progress == 3'd6 && $past(progress) == 3'd5));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (progress > 3'd1 && progress < 3'd6 && progress != $past(progress))
            |-> progress == $past(progress) + 3'd1);

    assert_write_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) && !ce_n && !we_n && progress < 3'd6) |=> progress == 3'd0);

    assert_busy_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) && !ce_n && busy && progress < 3'd6) |=> progress == 3'd0);

    assert_lock_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(progress) == 3'd6 && progress == 3'd6) |-> !(store_req || recall_req));

endmodule

bind unlock_seq_detect ulk_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .busy       (busy),
    .store_req  (store_req),
    .recall_req (recall_req),
    .progress   (progress)
);

// File: tb/unlock_seq_detect_tb_top.sv
module unlock_seq_detect_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        busy = 1'b0;
    logic        store_req, recall_req;
    logic [2:0]  progress;

    int errors = 0;
    int checks = 0;
    logic        obs_st, obs_rc;
    logic [2:0]  obs_prog;

    localparam logic [12:0] SEQ [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};

    always #10 clk = ~clk;   // 50 MHz

    unlock_seq_detect dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .busy(busy), .store_req(store_req),
        .recall_req(recall_req), .progress(progress)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected progress after one access, from the requirements.
    function automatic int model(input int p, input logic [12:0] a, input logic we,
                                 input logic bz, output logic st, output logic rc);
        st = 1'b0; rc = 1'b0;
        if (p >= 6) return p;
        if (bz || !we) return 0;
        if (p == 5 && a == 13'h0F0F) begin st = 1'b1; return 6; end
        if (p == 5 && a == 13'h0F0E) begin rc = 1'b1; return 6; end
        if (p < 5 && a == SEQ[p]) return p + 1;
        if (a == 13'h0000) return 1;
        return 0;
    endfunction

    // One access: low for one cycle, high for one cycle. Called at a negedge.
    task automatic access(input logic [12:0] a, input logic we, input logic oe, input logic bz);
        addr = a; we_n = we; oe_n = oe; busy = bz; ce_n = 1'b0;
        @(negedge clk);
        obs_st = store_req; obs_rc = recall_req; obs_prog = progress;
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk("R11 pulse one cycle", int'(store_req | recall_req), 0);
    endtask

    task automatic reach(input int p);
        for (int i = 0; i < p; i++) begin
            access(SEQ[i], 1'b1, 1'b1, 1'b0);
            chk("R3 prefix step", obs_prog, i + 1);
        end
    endtask

    task automatic release_lock();
        busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        busy = 1'b0;
        @(negedge clk);
        chk("R10 lock released", progress, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int exp_p;
        logic est, erc;
        repeat (3) @(negedge clk);
        chk("R1 reset progress", progress, 0);
        chk("R1 reset store", store_req, 0);
        chk("R1 reset recall", recall_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", progress, 0);

        // Store with no prior write
        reach(5);
        access(13'h0F0F, 1'b1, 1'b1, 1'b0);
        chk("R4 store pulse", obs_st, 1);
        chk("R11 no recall with store", obs_rc, 0);
        chk("R10 locked", obs_prog, 6);
        access(13'h0000, 1'b1, 1'b1, 1'b0);
        chk("R10 access ignored in lock", obs_prog, 6);
        busy = 1'b1;
        @(negedge clk);
        access(13'h0000, 1'b1, 1'b1, 1'b1);
        chk("R10 access ignored while running", obs_prog, 6);
        release_lock();

        // Recall with oe_n alternating
        for (int i = 0; i < 5; i++) begin
            access(SEQ[i], 1'b1, logic'(i % 2), 1'b0);
            chk("R8 oe_n ignored step", obs_prog, i + 1);
        end
        access(13'h0F0E, 1'b1, 1'b0, 1'b0);
        chk("R5 recall pulse", obs_rc, 1);
        chk("R11 no store with recall", obs_st, 0);
        release_lock();

        // Disruptor sweep at every prefix length
        for (int p = 0; p <= 5; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [12:0] a;
                logic we, bz;
                a  = (p < 5) ? SEQ[p] : 13'h0F0F;
                we = 1'b1; bz = 1'b0;
                if (k == 0) we = 1'b0;
                if (k == 1) a = 13'h1234;
                if (k == 2) a = 13'h0000;
                if (k == 3) bz = 1'b1;
                reach(p);
                exp_p = model(p, a, we, bz, est, erc);
                access(a, we, 1'b1, bz);
                case (k)
                    0: chk("R6 write aborts", obs_prog, exp_p);
                    1: chk("R7 wrong address aborts", obs_prog, exp_p);
                    2: chk("R7 restart on 0x0000", obs_prog, exp_p);
                    default: chk("R9 busy access aborts", obs_prog, exp_p);
                endcase
                chk("R9 no request after disruptor", int'(obs_st | obs_rc), int'(est | erc));
                busy = 1'b0;
                access(13'h1234, 1'b1, 1'b1, 1'b0);
            end
        end

        // Restart then complete from step two
        reach(3);
        access(13'h0000, 1'b1, 1'b1, 1'b0);
        chk("R7 restart mid-sequence", obs_prog, 1);
        for (int i = 1; i < 5; i++) begin
            access(SEQ[i], 1'b1, 1'b1, 1'b0);
            chk("R7 continue after restart", obs_prog, i + 1);
        end
        access(13'h0F0F, 1'b1, 1'b1, 1'b0);
        chk("R4 store after restart", obs_st, 1);
        release_lock();

        // Sixth-address sweep
        for (int a = 0; a < 8192; a += 5) begin
            logic [12:0] six;
            six = (a == 3850) ? 13'h0F0F : (a == 3855) ? 13'h0F0E : 13'(a);
            reach(5);
            exp_p = model(5, six, 1'b1, 1'b0, est, erc);
            access(six, 1'b1, 1'b1, 1'b0);
            chk("R4 store decode", obs_st, est);
            chk("R5 recall decode", obs_rc, erc);
            chk("R7 sixth step progress", obs_prog, exp_p);
            if (exp_p == 6) release_lock();
            else if (exp_p != 0) access(13'h1234, 1'b1, 1'b1, 1'b0);
        end

        // Held-low enable counts once
        addr = 13'h0000; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = 13'h1555;
        repeat (2) @(negedge clk);
        chk("R2 held low counts once", progress, 1);
        ce_n = 1'b1;
        @(negedge clk);
        access(13'h1555, 1'b1, 1'b1, 1'b0);
        chk("R2 next pulse counts", obs_prog, 2);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule